// File: doc/BRIEF.md
# DMA Channel Request Control Registers

This block is the per-channel control and status register file of a multi-channel DMA controller. It keeps five vectors with one bit per channel: hardware request enable, error-interrupt enable, interrupt status, error status and done status. Software changes single bits without a read-modify-write. It writes a channel number into one of eight byte-wide command registers, and each of these registers carries out a single action: set or clear a request enable, set or clear an error-interrupt enable, clear an interrupt, clear an error, clear a done flag, or issue a software start.

The block supports two layouts, picked by the channel-count parameter: 32 channels or 64 channels. The 64-channel layout adds upper-half words for the vectors. It also places the eight command bytes in a different order. The block drives the request-enable vector to the channel arbiter and a one-cycle software-start vector. It receives one-cycle interrupt, error and done event pulses from the transfer engine for each channel. The register bus is a simple single-cycle port with byte enables. Reads are combinational.

Top module: `dma_chreq_regs`

## Requirements
- R1: After reset, every vector, the control word and every output are zero.
- R2: Writing channel number N to the set-request byte sets bit N of `req_en_o`, and writing N to the clear-request byte clears it. The bytes are at 0x1B (set) and 0x1A (clear) in the 32-channel layout, and at 0x18 (set) and 0x19 (clear) in the 64-channel layout.
- R3: In a command byte, bit 6 set applies the command to every channel. Bit 7 is ignored. Only the low log2(channel count) bits select the channel, so in the 32-channel layout the value 33 addresses channel 1.
- R4: The error-interrupt-enable vector is set by writing to 0x19 and cleared by writing to 0x18 in the 32-channel layout. In the 64-channel layout it is set at 0x1A and cleared at 0x1B. `err_irq_o` is high while some channel has both its error bit and its error-interrupt enable set.
- R5: An interrupt event pulse sets that channel's interrupt bit. The clear-interrupt byte (0x1F in the 32-channel layout, 0x1C in the 64-channel layout) clears it. `irq_o` is high while any interrupt bit is set.
- R6: An error event pulse sets that channel's error bit, and the clear-error byte (0x1E in the 32-channel layout, 0x1D in the 64-channel layout) clears it. The word at 0x04 reads bit 31 = any error set and bits 5:0 = the lowest-numbered channel with an error.
- R7: A done event pulse sets that channel's bit of `done_o`. The clear-done byte (0x1C in the 32-channel layout, 0x1F in the 64-channel layout) clears it.
- R8: Writing N to the set-start byte (0x1D in the 32-channel layout, 0x1E in the 64-channel layout) raises bit N of `sw_start_o` for exactly the one cycle after the write.
- R9: When an event pulse and a clear command hit the same channel in the same cycle, the bit ends up set.
- R10: These words are readable, with the low half at the first offset and the high half at the second: request enable 0x0C/0x08, error-interrupt enable 0x14/0x10, interrupt 0x24/0x20, error 0x2C/0x28. The request-enable and error-interrupt-enable words can also be written directly under byte enables. In the 32-channel layout the high words read zero and writes to them are ignored.
- R11: A word write to 0x18 or 0x1C with several byte enables carries out each enabled byte's command in the same cycle. If a set and a clear of the same vector hit the same bit, the set wins. Reads of 0x18 and 0x1C return zero.
- R12: The control word at 0x00 is read/write under byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored and lanes are chosen by bus_be |
| bus_be | input | 4 | Byte enables, lane k = bits 8k+7:8k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ev_int | input | NUM_CH | Per-channel interrupt event pulses |
| ev_err | input | NUM_CH | Per-channel error event pulses |
| ev_done | input | NUM_CH | Per-channel done event pulses |
| req_en_o | output | NUM_CH | Request-enable vector to the arbiter |
| sw_start_o | output | NUM_CH | One-cycle software start requests |
| done_o | output | NUM_CH | Done status vector |
| irq_o | output | 1 | Any interrupt bit set |
| err_irq_o | output | 1 | Any enabled error bit set |

## Verification
The command path is exercised with single channel numbers, the all-channels bit, a channel value above the channel count that must alias, and a value with bit 7 set. Together these separate a correct channel decode from a full-byte decode and from a decode with no broadcast. Multi-lane word writes with a set and a clear on the same bit show whether the lanes combine and which one has priority. Both layouts are instantiated side by side and driven with the same kinds of commands, so a swapped byte order in either table produces a wrong vector. A clear command that arrives together with an event shows whether events take priority over clears.

// File: rtl/dma_chreq_pkg.sv
package dma_chreq_pkg;

   typedef enum logic [2:0] {
      OP_SET_REQ   = 3'd0,
      OP_CLR_REQ   = 3'd1,
      OP_SET_EEI   = 3'd2,
      OP_CLR_EEI   = 3'd3,
      OP_CLR_INT   = 3'd4,
      OP_CLR_ERR   = 3'd5,
      OP_SET_START = 3'd6,
      OP_CLR_DONE  = 3'd7
   } chreq_op_e;

   localparam int NUM_OPS     = 8;
   localparam int CMD_ALL_BIT = 6;

   localparam logic [5:0] OFS_CTRL    = 6'h00;
   localparam logic [5:0] OFS_ERRSUM  = 6'h04;
   localparam logic [5:0] OFS_REQ_HI  = 6'h08;
   localparam logic [5:0] OFS_REQ_LO  = 6'h0C;
   localparam logic [5:0] OFS_EEI_HI  = 6'h10;
   localparam logic [5:0] OFS_EEI_LO  = 6'h14;
   localparam logic [5:0] OFS_CMD_A   = 6'h18;
   localparam logic [5:0] OFS_CMD_B   = 6'h1C;
   localparam logic [5:0] OFS_INT_HI  = 6'h20;
   localparam logic [5:0] OFS_INT_LO  = 6'h24;
   localparam logic [5:0] OFS_ERR_HI  = 6'h28;
   localparam logic [5:0] OFS_ERR_LO  = 6'h2C;

   // Command byte at offset 0x18 + idx; the order depends on the layout.
   function automatic chreq_op_e op_for_lane(input bit wide, input logic [2:0] idx);
      chreq_op_e op;
      if (wide) begin
         case (idx)
            3'd0: op = OP_SET_REQ;
            3'd1: op = OP_CLR_REQ;
            3'd2: op = OP_SET_EEI;
            3'd3: op = OP_CLR_EEI;
            3'd4: op = OP_CLR_INT;
            3'd5: op = OP_CLR_ERR;
            3'd6: op = OP_SET_START;
            default: op = OP_CLR_DONE;
         endcase
      end else begin
         case (idx)
            3'd0: op = OP_CLR_EEI;
            3'd1: op = OP_SET_EEI;
            3'd2: op = OP_CLR_REQ;
            3'd3: op = OP_SET_REQ;
            3'd4: op = OP_CLR_DONE;
            3'd5: op = OP_SET_START;
            3'd6: op = OP_CLR_ERR;
            default: op = OP_CLR_INT;
         endcase
      end
      return op;
   endfunction

   function automatic logic [5:0] lowest_set(input logic [63:0] v);
      logic [5:0] idx;
      idx = '0;
      for (int i = 63; i >= 0; i--) begin
         if (v[i]) idx = 6'(i);
      end
      return idx;
   endfunction

   function automatic logic [31:0] be_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/dma_chreq_lane.sv
module dma_chreq_lane
   import dma_chreq_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int LANE   = 0,
   parameter bit WIDE   = 1'b0
) (
   input  logic              hit,
   input  logic [7:0]        cmd_byte,
   output logic [NUM_OPS-1:0] op_hot,
   output logic [NUM_CH-1:0] mask
);
   localparam int        CH_W = $clog2(NUM_CH);
   localparam chreq_op_e OP   = op_for_lane(WIDE, 3'(LANE));

   logic [CH_W-1:0] ch;
   logic            unused_cmd_bits;

   assign ch              = cmd_byte[CH_W-1:0];
   assign unused_cmd_bits = ^cmd_byte;
   assign op_hot          = hit ? (NUM_OPS'(1) << OP) : '0;
   assign mask            = cmd_byte[CMD_ALL_BIT] ? '1 : (NUM_CH'(1) << ch);
endmodule

// File: rtl/dma_chreq_vec.sv
module dma_chreq_vec #(
   parameter int NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] load_m,
   input  logic [NUM_CH-1:0] load_v,
   input  logic [NUM_CH-1:0] clr_m,
   input  logic [NUM_CH-1:0] set_m,
   output logic [NUM_CH-1:0] q
);
   logic [NUM_CH-1:0] d;

   // Direct load first, then clears, then sets: sets and events win.
   always_comb begin
      d = (q & ~load_m) | (load_v & load_m);
      d = d & ~clr_m;
      d = d | set_m;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/dma_chreq_regs.sv
module dma_chreq_regs
   import dma_chreq_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_CH-1:0] ev_int,
   input  logic [NUM_CH-1:0] ev_err,
   input  logic [NUM_CH-1:0] ev_done,
   output logic [NUM_CH-1:0] req_en_o,
   output logic [NUM_CH-1:0] sw_start_o,
   output logic [NUM_CH-1:0] done_o,
   output logic              irq_o,
   output logic              err_irq_o
);
   localparam bit WIDE  = (NUM_CH == 64);
   localparam int LANES = 8;

   if (NUM_CH != 32 && NUM_CH != 64) begin : g_bad_ch
      $error("dma_chreq_regs: NUM_CH must be 32 or 64");
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $error("dma_chreq_regs: ADDR_W must be at least 6");
   end

   logic [5:0]  ofs;
   logic        in_range;
   logic        wr_ok;
   logic        unused_addr;
   logic [31:0] wmask;

   assign ofs         = {bus_addr[5:2], 2'b00};
   assign in_range    = ((bus_addr >> 6) == '0);
   assign wr_ok       = bus_sel && bus_wr && in_range;
   assign unused_addr = ^bus_addr[1:0];
   assign wmask       = be_mask(bus_be);

   // ---------------- command byte lanes ----------------
   logic [NUM_OPS-1:0] lane_hot  [LANES];
   logic [NUM_CH-1:0]  lane_mask [LANES];
   logic [NUM_CH-1:0]  op_mask   [NUM_OPS];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [5:0] WORD = (k < 4) ? OFS_CMD_A : OFS_CMD_B;
      logic hit;
      assign hit = wr_ok && (ofs == WORD) && bus_be[k % 4];
      dma_chreq_lane #(.NUM_CH(NUM_CH), .LANE(k), .WIDE(WIDE)) u_lane (
         .hit      (hit),
         .cmd_byte (bus_wdata[8*(k%4) +: 8]),
         .op_hot   (lane_hot[k]),
         .mask     (lane_mask[k])
      );
   end

   always_comb begin
      for (int o = 0; o < NUM_OPS; o++) begin
         op_mask[o] = '0;
         for (int k = 0; k < LANES; k++) begin
            if (lane_hot[k][o]) op_mask[o] = op_mask[o] | lane_mask[k];
         end
      end
   end

   // ---------------- direct word loads ----------------
   logic [63:0] req_lm64, eei_lm64, wdata64;
   logic [NUM_CH-1:0] req_lm, eei_lm, load_v;

   assign wdata64 = {bus_wdata, bus_wdata};

   if (WIDE) begin : g_hi_load
      assign req_lm64 = {(wr_ok && ofs == OFS_REQ_HI) ? wmask : 32'h0,
                         (wr_ok && ofs == OFS_REQ_LO) ? wmask : 32'h0};
      assign eei_lm64 = {(wr_ok && ofs == OFS_EEI_HI) ? wmask : 32'h0,
                         (wr_ok && ofs == OFS_EEI_LO) ? wmask : 32'h0};
   end else begin : g_lo_load
      assign req_lm64 = {32'h0, (wr_ok && ofs == OFS_REQ_LO) ? wmask : 32'h0};
      assign eei_lm64 = {32'h0, (wr_ok && ofs == OFS_EEI_LO) ? wmask : 32'h0};
   end

   assign req_lm = req_lm64[NUM_CH-1:0];
   assign eei_lm = eei_lm64[NUM_CH-1:0];
   assign load_v = wdata64[NUM_CH-1:0];

   logic [63:0]       hi_unused;
   logic              unused_hi;
   assign hi_unused = req_lm64 | eei_lm64 | wdata64;
   assign unused_hi = ^hi_unused;

   // ---------------- vectors ----------------
   logic [NUM_CH-1:0] req_q, eei_q, int_q, err_q, done_q, start_q;
   localparam logic [NUM_CH-1:0] NONE = '0;

   dma_chreq_vec #(.NUM_CH(NUM_CH)) u_req (
      .clk(clk), .rst_n(rst_n), .load_m(req_lm), .load_v(load_v),
      .clr_m(op_mask[OP_CLR_REQ]), .set_m(op_mask[OP_SET_REQ]), .q(req_q));

   dma_chreq_vec #(.NUM_CH(NUM_CH)) u_eei (
      .clk(clk), .rst_n(rst_n), .load_m(eei_lm), .load_v(load_v),
      .clr_m(op_mask[OP_CLR_EEI]), .set_m(op_mask[OP_SET_EEI]), .q(eei_q));

   dma_chreq_vec #(.NUM_CH(NUM_CH)) u_int (
      .clk(clk), .rst_n(rst_n), .load_m(NONE), .load_v(NONE),
      .clr_m(op_mask[OP_CLR_INT]), .set_m(ev_int), .q(int_q));

   dma_chreq_vec #(.NUM_CH(NUM_CH)) u_err (
      .clk(clk), .rst_n(rst_n), .load_m(NONE), .load_v(NONE),
      .clr_m(op_mask[OP_CLR_ERR]), .set_m(ev_err), .q(err_q));

   dma_chreq_vec #(.NUM_CH(NUM_CH)) u_done (
      .clk(clk), .rst_n(rst_n), .load_m(NONE), .load_v(NONE),
      .clr_m(op_mask[OP_CLR_DONE]), .set_m(ev_done), .q(done_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= '0;
      else        start_q <= op_mask[OP_SET_START];
   end

   // ---------------- control word ----------------
   logic [31:0] ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ctrl_q <= '0;
      else if (wr_ok && ofs == OFS_CTRL)  ctrl_q <= (ctrl_q & ~wmask) | (bus_wdata & wmask);
   end

   // ---------------- read mux ----------------
   logic [63:0] req64, eei64, int64, err64;
   assign req64 = 64'(req_q);
   assign eei64 = 64'(eei_q);
   assign int64 = 64'(int_q);
   assign err64 = 64'(err_q);

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         case (ofs)
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_ERRSUM: bus_rdata = {(|err64), 25'h0, lowest_set(err64)};
            OFS_REQ_HI: bus_rdata = req64[63:32];
            OFS_REQ_LO: bus_rdata = req64[31:0];
            OFS_EEI_HI: bus_rdata = eei64[63:32];
            OFS_EEI_LO: bus_rdata = eei64[31:0];
            OFS_INT_HI: bus_rdata = int64[63:32];
            OFS_INT_LO: bus_rdata = int64[31:0];
            OFS_ERR_HI: bus_rdata = err64[63:32];
            OFS_ERR_LO: bus_rdata = err64[31:0];
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign req_en_o   = req_q;
   assign sw_start_o = start_q;
   assign done_o     = done_q;
   assign irq_o      = |int_q;
   assign err_irq_o  = |(err_q & eei_q);
endmodule

// File: rtl/dma_chreq_chk.sv
module dma_chreq_chk #(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [NUM_CH-1:0] ev_int,
   input logic [NUM_CH-1:0] ev_done,
   input logic [NUM_CH-1:0] int_q,
   input logic [NUM_CH-1:0] req_en_o,
   input logic [NUM_CH-1:0] sw_start_o,
   input logic [NUM_CH-1:0] done_o
);
   a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_en_o == '0 && sw_start_o == '0 && done_o == '0));

   a_r2_req_by_bus_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(req_en_o) |-> $past(bus_sel && bus_wr));

   a_r8_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|sw_start_o) |-> $past(bus_sel && bus_wr));

   a_r9_int_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_int) |=> ((int_q & $past(ev_int)) == $past(ev_int)));

   a_r7_done_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_done) |=> ((done_o & $past(ev_done)) == $past(ev_done)));

   a_r11_cmd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (bus_addr == ADDR_W'(8'h18) || bus_addr == ADDR_W'(8'h1C)))
         |-> bus_rdata == 32'h0);
endmodule

bind dma_chreq_regs dma_chreq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ev_int(ev_int),
   .ev_done(ev_done), .int_q(int_q), .req_en_o(req_en_o),
   .sw_start_o(sw_start_o), .done_o(done_o));

// File: tb/dma_chreq_regs_test.sv
module dma_chreq_regs_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        wr = 0, sel32 = 0, sel64 = 0;
   logic [7:0]  addr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata32, rdata64;
   logic [31:0] ev_int32 = '0, ev_err32 = '0, ev_done32 = '0;
   logic [63:0] ev_int64 = '0, ev_err64 = '0, ev_done64 = '0;
   logic [31:0] req32, start32, done32;
   logic [63:0] req64, start64, done64;
   logic        irq32, eirq32, irq64, eirq64;

   dma_chreq_regs #(.NUM_CH(32), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel32), .bus_wr(wr), .bus_addr(addr),
      .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata32),
      .ev_int(ev_int32), .ev_err(ev_err32), .ev_done(ev_done32),
      .req_en_o(req32), .sw_start_o(start32), .done_o(done32),
      .irq_o(irq32), .err_irq_o(eirq32));

   dma_chreq_regs #(.NUM_CH(64), .ADDR_W(8)) uut64 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel64), .bus_wr(wr), .bus_addr(addr),
      .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata64),
      .ev_int(ev_int64), .ev_err(ev_err64), .ev_done(ev_done64),
      .req_en_o(req64), .sw_start_o(start64), .done_o(done64),
      .irq_o(irq64), .err_irq_o(eirq64));

   int checks = 0, failures = 0;
   bit timed_out = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input bit w64, input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      addr = a; be = b; wdata = d; wr = 1; sel32 = !w64; sel64 = w64;
      @(negedge clk);
      sel32 = 0; sel64 = 0; wr = 0; be = '0;
   endtask

   task automatic brd(input bit w64, input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; wr = 0; sel32 = !w64; sel64 = w64;
      #1 d = w64 ? rdata64 : rdata32;
      sel32 = 0; sel64 = 0;
   endtask

   typedef struct packed {
      logic [7:0]  a;
      logic [3:0]  be;
      logic [31:0] d;
      logic [7:0]  ra;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   // 32-channel layout, state carried from entry to entry
   localparam vec_t TBL [16] = '{
      '{8'h1B, 4'b1000, 32'h0500_0000, 8'h0C, 32'h0000_0020, 8'd2},  // R2 set ch5
      '{8'h1B, 4'b1000, 32'h0000_0000, 8'h0C, 32'h0000_0021, 8'd2},  // R2 set ch0
      '{8'h1A, 4'b0100, 32'h0005_0000, 8'h0C, 32'h0000_0001, 8'd2},  // R2 clear ch5
      '{8'h1B, 4'b1000, 32'h4000_0000, 8'h0C, 32'hFFFF_FFFF, 8'd3},  // R3 all
      '{8'h1A, 4'b0100, 32'h0021_0000, 8'h0C, 32'hFFFF_FFFD, 8'd3},  // R3 33 -> ch1
      '{8'h1A, 4'b0100, 32'h00C0_0000, 8'h0C, 32'h0000_0000, 8'd3},  // R3 bit7 ignored
      '{8'h19, 4'b0010, 32'h0000_0300, 8'h14, 32'h0000_0008, 8'd4},  // R4 set eei ch3
      '{8'h0C, 4'b0001, 32'h0000_00A5, 8'h0C, 32'h0000_00A5, 8'd10}, // R10 byte load
      '{8'h0C, 4'b0010, 32'h0000_3C00, 8'h0C, 32'h0000_3CA5, 8'd10}, // R10 byte load
      '{8'h08, 4'b1111, 32'hFFFF_FFFF, 8'h08, 32'h0000_0000, 8'd10}, // R10 no high word
      '{8'h18, 4'b1100, 32'h0800_0000, 8'h0C, 32'h0000_3DA4, 8'd11}, // R11 two lanes
      '{8'h18, 4'b1100, 32'h0101_0000, 8'h0C, 32'h0000_3DA6, 8'd11}, // R11 set wins
      '{8'h18, 4'b0000, 32'h0000_0000, 8'h18, 32'h0000_0000, 8'd11}, // R11 read zero
      '{8'h1C, 4'b0000, 32'h0000_0000, 8'h1C, 32'h0000_0000, 8'd11}, // R11 read zero
      '{8'h00, 4'b0101, 32'h1234_5678, 8'h00, 32'h0034_0078, 8'd12}, // R12 ctrl
      '{8'h18, 4'b0001, 32'h0000_0003, 8'h14, 32'h0000_0000, 8'd4}   // R4 clear eei ch3
   };

   task automatic run_all();
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 req32", 64'(req32), 0);
      chk("R1 req64", req64, 0);
      chk("R1 outs", {60'h0, irq32, eirq32, irq64, eirq64}, 0);
      @(negedge clk) rst_n = 1;
      brd(0, 8'h00, v); chk("R1 ctrl", 64'(v), 0);
      brd(1, 8'h08, v); chk("R1 req hi", 64'(v), 0);

      foreach (TBL[i]) begin
         bwr(0, TBL[i].a, TBL[i].be, TBL[i].d);
         brd(0, TBL[i].ra, v);
         chk($sformatf("R%0d table[%0d]", TBL[i].req, i), 64'(v), 64'(TBL[i].exp));
      end
      chk("R2 req port", 64'(req32), 64'h3DA6);

      // R5: interrupt event and clear
      @(negedge clk) ev_int32 = 32'h10;
      @(negedge clk) ev_int32 = '0;
      brd(0, 8'h24, v); chk("R5 int set", 64'(v), 64'h10);
      chk("R5 irq high", 64'(irq32), 1);
      bwr(0, 8'h1C, 4'b1000, 32'h0400_0000);
      brd(0, 8'h24, v); chk("R5 int clr", 64'(v), 0);
      chk("R5 irq low", 64'(irq32), 0);

      // R6 / R4: errors, summary word, enabled error irq
      @(negedge clk) ev_err32 = 32'h88;
      @(negedge clk) ev_err32 = '0;
      brd(0, 8'h2C, v); chk("R6 err word", 64'(v), 64'h88);
      brd(0, 8'h04, v); chk("R6 summary", 64'(v), 64'h8000_0003);
      chk("R4 eirq off", 64'(eirq32), 0);
      bwr(0, 8'h18, 4'b0010, 32'h0000_0700);
      chk("R4 eirq on", 64'(eirq32), 1);
      bwr(0, 8'h1C, 4'b0100, 32'h0003_0000);
      brd(0, 8'h04, v); chk("R6 summary after clr", 64'(v), 64'h8000_0007);
      bwr(0, 8'h1C, 4'b0100, 32'h0040_0000);
      brd(0, 8'h04, v); chk("R6 summary empty", 64'(v), 0);

      // R7: done
      @(negedge clk) ev_done32 = 32'h4;
      @(negedge clk) ev_done32 = '0;
      chk("R7 done set", 64'(done32), 64'h4);
      bwr(0, 8'h1C, 4'b0001, 32'h0000_0002);
      chk("R7 done clr", 64'(done32), 0);

      // R8: software start pulse
      bwr(0, 8'h1C, 4'b0010, 32'h0000_0900);
      chk("R8 start pulse", 64'(start32), 64'h200);
      @(negedge clk);
      chk("R8 start gone", 64'(start32), 0);

      // R9: event and clear on the same channel, same cycle
      @(negedge clk);
      ev_int32 = 32'h40; ev_done32 = 32'h40;
      addr = 8'h1C; be = 4'b1001; wdata = 32'h0600_0006; wr = 1; sel32 = 1;
      @(negedge clk);
      ev_int32 = '0; ev_done32 = '0; sel32 = 0; wr = 0; be = '0;
      brd(0, 8'h24, v); chk("R9 int kept", 64'(v), 64'h40);
      chk("R9 done kept", 64'(done32), 64'h40);

      // 64-channel layout
      bwr(1, 8'h18, 4'b0001, 32'h0000_003F);
      chk("R2 wide set ch63", req64, 64'h8000_0000_0000_0000);
      brd(1, 8'h08, v); chk("R10 wide hi", 64'(v), 64'h8000_0000);
      brd(1, 8'h0C, v); chk("R10 wide lo", 64'(v), 0);
      bwr(1, 8'h18, 4'b0010, 32'h0000_3F00);
      chk("R2 wide clr", req64, 0);
      bwr(1, 8'h1C, 4'b0100, 32'h0021_0000);
      chk("R8 wide start", start64, 64'h2_0000_0000);
      bwr(1, 8'h18, 4'b0100, 32'h0005_0000);
      brd(1, 8'h14, v); chk("R4 wide eei", 64'(v), 64'h20);
      @(negedge clk) ev_int64 = 64'h100_0000_0000;
      @(negedge clk) ev_int64 = '0;
      brd(1, 8'h20, v); chk("R5 wide int", 64'(v), 64'h100);
      bwr(1, 8'h1C, 4'b0001, 32'h0000_0028);
      brd(1, 8'h20, v); chk("R5 wide clr", 64'(v), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      if (timed_out) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule